// File: doc/BRIEF.md
# Dual-Port Banked Cache Data Array

This block holds the data half of a two-way set-associative data cache with 64-byte lines and 32 KB per way. Each line is spread over eight single-ported banks, each one 64-bit word wide, so that two load/store ports can reach the array in the same cycle without a multi-ported memory. Every port access touches one bank in both ways at once. The read returns the word from each way, and tag logic outside the block picks the way that hit.

Each port presents an index address (byte offset, bank and set), a request, a read/write select, a write way, write data and byte enables. When both ports want the same bank in the same cycle, port 0 is served. Port 1 is told in that cycle to retry, and its access is dropped. Read results are registered and come with a valid flag one cycle after the request.

Top module: `dual_bank_data_array`

## Requirements
- R1: Address bits [5:3] pick the bank, bits [14:6] pick the set, and bits [2:0] are ignored. Two addresses that differ only in bits [2:0] reach the same word, and consecutive 8-byte words sit in adjacent banks.
- R2: When both ports request and their bank fields differ, both accesses are performed in that cycle, and p1Retry stays low.
- R3: A read request performed in cycle N drives that port's valid high in cycle N+1, with the stored word of way 0 on RdWay0 and the stored word of way 1 on RdWay1.
- R4: When both ports request and their bank fields are equal, p1Retry is high in that same cycle. Port 1's access is not performed: its write leaves the array unchanged, and p1Valid stays low in the next cycle.
- R5: Port 0's request is always performed, whether or not there is a conflict.
- R6: A write changes only the way given by its way input (0 or 1). Within the 64-bit word it changes only byte k, data bits [8k+7:8k], for each enable bit k that is set.
- R7: A write request produces no read valid in the next cycle.
- R8: p1Retry is low whenever either port is idle, even if the idle port's address selects the same bank.
- R9: After reset, both valids and p1Retry are low and all four read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| p0Req | input | 1 | Port 0 access request |
| p0Wr | input | 1 | Port 0 write (1) or read (0) |
| p0Way | input | 1 | Port 0 way to write |
| p0Addr | input | 15 | Port 0 index address |
| p0WData | input | 64 | Port 0 write data |
| p0Be | input | 8 | Port 0 byte enables |
| p1Req | input | 1 | Port 1 access request |
| p1Wr | input | 1 | Port 1 write (1) or read (0) |
| p1Way | input | 1 | Port 1 way to write |
| p1Addr | input | 15 | Port 1 index address |
| p1WData | input | 64 | Port 1 write data |
| p1Be | input | 8 | Port 1 byte enables |
| p1Retry | output | 1 | Port 1 lost a bank conflict this cycle |
| p0Valid | output | 1 | Port 0 read data valid |
| p0RdWay0 | output | 64 | Port 0 word from way 0 |
| p0RdWay1 | output | 64 | Port 0 word from way 1 |
| p1Valid | output | 1 | Port 1 read data valid |
| p1RdWay0 | output | 64 | Port 1 word from way 0 |
| p1RdWay1 | output | 64 | Port 1 word from way 1 |

## Verification
Two port accesses can fall in the same cycle. If they target different banks, both must complete. If they target the same bank, the arbitration must drop port 1. Random traffic with both ports active is confined to a few sets so that same-bank pairs are frequent. Each cycle, the bench compares p1Retry with its own compare of address bits [5:3]. A shadow copy of both ways, updated only for accesses the bench expects to be performed, then judges every read. A write by port 1 that was dropped without notice therefore shows up as a data mismatch. Directed cases add a write/write collision, a one-sided request that lands on the same bank, partial byte enables, the last set, and the ignored byte-offset bits.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int WORD_W  = 64;
  localparam int BE_W    = WORD_W / 8;
  localparam int BANKS   = 8;
  localparam int SETS    = 512;
  localparam int WAYS    = 2;
  localparam int PORTS   = 2;
  localparam int BANK_W  = $clog2(BANKS);
  localparam int SET_W   = $clog2(SETS);
  localparam int BYTE_W  = $clog2(BE_W);
  localparam int ADDR_W  = SET_W + BANK_W + BYTE_W;

  // per-bank command issued by control to the storage
  typedef struct packed {
    logic             en;
    logic             we;
    logic             way;
    logic             src;   // 0: port 0 owns the bank, 1: port 1
    logic [SET_W-1:0] set;
  } bankCmd_t;

  typedef struct packed {
    bankCmd_t [BANKS-1:0]              cmd;
    logic     [PORTS-1:0][BANK_W-1:0]  rdSel;  // registered bank of last read
  } ctrlStrobes_t;
endpackage

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
  import dcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              p0Req,
  input  logic              p0Wr,
  input  logic              p0Way,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic              p1Req,
  input  logic              p1Wr,
  input  logic              p1Way,
  input  logic [ADDR_W-1:0] p1Addr,
  output logic              p1Retry,
  output logic              p0Valid,
  output logic              p1Valid,
  output ctrlStrobes_t      strobes
);
  logic [BANK_W-1:0] bank0, bank1;
  logic [SET_W-1:0]  set0, set1;
  logic              conflict, grant1;
  logic [PORTS-1:0][BANK_W-1:0] selQ;
  logic              unusedByteBits;

  assign bank0 = p0Addr[BYTE_W +: BANK_W];
  assign bank1 = p1Addr[BYTE_W +: BANK_W];
  assign set0  = p0Addr[BYTE_W+BANK_W +: SET_W];
  assign set1  = p1Addr[BYTE_W+BANK_W +: SET_W];
  assign unusedByteBits = ^{p0Addr[BYTE_W-1:0], p1Addr[BYTE_W-1:0]};

  assign conflict = p0Req && p1Req && (bank0 == bank1);
  assign grant1   = p1Req && !conflict;
  assign p1Retry  = conflict;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      strobes.cmd[b] = '0;
      if (p0Req && bank0 == BANK_W'(b)) begin
        strobes.cmd[b].en  = 1'b1;
        strobes.cmd[b].we  = p0Wr;
        strobes.cmd[b].way = p0Way;
        strobes.cmd[b].src = 1'b0;
        strobes.cmd[b].set = set0;
      end else if (grant1 && bank1 == BANK_W'(b)) begin
        strobes.cmd[b].en  = 1'b1;
        strobes.cmd[b].we  = p1Wr;
        strobes.cmd[b].way = p1Way;
        strobes.cmd[b].src = 1'b1;
        strobes.cmd[b].set = set1;
      end
    end
    strobes.rdSel = selQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0Valid <= 1'b0;
      p1Valid <= 1'b0;
      selQ    <= '0;
    end else begin
      p0Valid <= p0Req && !p0Wr;
      p1Valid <= grant1 && !p1Wr;
      if (p0Req && !p0Wr) selQ[0] <= bank0;
      if (grant1 && !p1Wr) selQ[1] <= bank1;
    end
  end
endmodule

// File: rtl/dcb_datapath.sv
module dcb_datapath
  import dcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] p0WData,
  input  logic [BE_W-1:0]   p0Be,
  input  logic [WORD_W-1:0] p1WData,
  input  logic [BE_W-1:0]   p1Be,
  output logic [WORD_W-1:0] p0RdWay0,
  output logic [WORD_W-1:0] p0RdWay1,
  output logic [WORD_W-1:0] p1RdWay0,
  output logic [WORD_W-1:0] p1RdWay1
);
  logic [WORD_W-1:0] rdWord [WAYS][BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] wd;
    logic [BE_W-1:0]   be;
    bankCmd_t          c;
    assign c  = strobes.cmd[b];
    assign wd = c.src ? p1WData : p0WData;
    assign be = c.src ? p1Be : p0Be;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [WORD_W-1:0] mem [SETS];
      logic [WORD_W-1:0] q;

      always_ff @(posedge clk) begin
        if (c.en && c.we && c.way == 1'(w)) begin
          for (int k = 0; k < BE_W; k++)
            if (be[k]) mem[c.set][k*8 +: 8] <= wd[k*8 +: 8];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             q <= '0;
        else if (c.en && !c.we) q <= mem[c.set];
      end

      assign rdWord[w][b] = q;
    end
  end

  assign p0RdWay0 = rdWord[0][strobes.rdSel[0]];
  assign p0RdWay1 = rdWord[1][strobes.rdSel[0]];
  assign p1RdWay0 = rdWord[0][strobes.rdSel[1]];
  assign p1RdWay1 = rdWord[1][strobes.rdSel[1]];
endmodule

// File: rtl/dual_bank_data_array.sv
module dual_bank_data_array
  import dcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              p0Req,
  input  logic              p0Wr,
  input  logic              p0Way,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic [WORD_W-1:0] p0WData,
  input  logic [BE_W-1:0]   p0Be,
  input  logic              p1Req,
  input  logic              p1Wr,
  input  logic              p1Way,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic [WORD_W-1:0] p1WData,
  input  logic [BE_W-1:0]   p1Be,
  output logic              p1Retry,
  output logic              p0Valid,
  output logic [WORD_W-1:0] p0RdWay0,
  output logic [WORD_W-1:0] p0RdWay1,
  output logic              p1Valid,
  output logic [WORD_W-1:0] p1RdWay0,
  output logic [WORD_W-1:0] p1RdWay1
);
  ctrlStrobes_t strobes;

  dcb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .p0Req(p0Req), .p0Wr(p0Wr), .p0Way(p0Way), .p0Addr(p0Addr),
    .p1Req(p1Req), .p1Wr(p1Wr), .p1Way(p1Way), .p1Addr(p1Addr),
    .p1Retry(p1Retry), .p0Valid(p0Valid), .p1Valid(p1Valid),
    .strobes(strobes)
  );

  dcb_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .p0WData(p0WData), .p0Be(p0Be), .p1WData(p1WData), .p1Be(p1Be),
    .p0RdWay0(p0RdWay0), .p0RdWay1(p0RdWay1),
    .p1RdWay0(p1RdWay0), .p1RdWay1(p1RdWay1)
  );
endmodule

// File: rtl/dual_bank_data_array_chk.sv
module dual_bank_data_array_chk
  import dcb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              p0Req,
  input logic              p0Wr,
  input logic [ADDR_W-1:0] p0Addr,
  input logic              p1Req,
  input logic              p1Wr,
  input logic [ADDR_W-1:0] p1Addr,
  input logic              p1Retry,
  input logic              p0Valid,
  input logic              p1Valid
);
  logic sameBank;
  assign sameBank = p0Addr[BYTE_W +: BANK_W] == p1Addr[BYTE_W +: BANK_W];

  a_r4_conflict_retry: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && p1Req && sameBank) |-> p1Retry);
  a_r2_no_false_retry: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && p1Req && !sameBank) |-> !p1Retry);
  a_r8_idle_no_retry: assert property (@(posedge clk) disable iff (!rstN)
    (!p0Req || !p1Req) |-> !p1Retry);
  a_r4_dropped_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    p1Retry |=> !p1Valid);
  a_r5_port0_read_served: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && !p0Wr) |=> p0Valid);
  a_r3_port1_read_served: assert property (@(posedge clk) disable iff (!rstN)
    (p1Req && !p1Wr && !p1Retry) |=> p1Valid);
  a_r7_write_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && p0Wr) |=> !p0Valid);
endmodule

bind dual_bank_data_array dual_bank_data_array_chk i_chk (.*);

// File: tb/test_dual_bank_data_array.sv
module test_dual_bank_data_array;
  import dcb_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic p0Req = 0, p0Wr = 0, p0Way = 0, p1Req = 0, p1Wr = 0, p1Way = 0;
  logic [ADDR_W-1:0] p0Addr = '0, p1Addr = '0;
  logic [WORD_W-1:0] p0WData = '0, p1WData = '0;
  logic [BE_W-1:0] p0Be = '0, p1Be = '0;
  logic p1Retry, p0Valid, p1Valid;
  logic [WORD_W-1:0] p0RdWay0, p0RdWay1, p1RdWay0, p1RdWay1;

  always #2 clk = ~clk;  // 250 MHz

  dual_bank_data_array i_dual_bank_data_array (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WORD_W-1:0] shadow [WAYS][4*BANKS];
  int setPick [4] = '{0, 1, 2, 511};

  // pending expectations for the next cycle
  bit expV0 = 0, expV1 = 0;
  logic [WORD_W-1:0] exp00, exp01, exp10, exp11;
  string tag0 = "R3", tag1 = "R3";

  task automatic chk(bit ok, string req, string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int slot(logic [ADDR_W-1:0] a);
    int s = int'(a[BYTE_W+BANK_W +: SET_W]);
    int si = (s == 511) ? 3 : s;
    return si * BANKS + int'(a[BYTE_W +: BANK_W]);
  endfunction

  function automatic logic [WORD_W-1:0] merge(logic [WORD_W-1:0] old, logic [WORD_W-1:0] nw, logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r = old;
    for (int k = 0; k < BE_W; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mkAddr(int s, int b, int off);
    return {SET_W'(s), BANK_W'(b), BYTE_W'(off)};
  endfunction

  // one cycle: check previous results, drive new inputs, check retry, update model
  task automatic step(bit r0, bit w0, bit y0, logic [ADDR_W-1:0] a0, logic [WORD_W-1:0] d0, logic [BE_W-1:0] b0,
                      bit r1, bit w1, bit y1, logic [ADDR_W-1:0] a1, logic [WORD_W-1:0] d1, logic [BE_W-1:0] b1,
                      string t0 = "R3", string t1 = "R3");
    bit conf;
    @(negedge clk);
    chk(p0Valid == expV0, tag0, "p0Valid", WORD_W'(p0Valid), WORD_W'(expV0));
    chk(p1Valid == expV1, tag1, "p1Valid", WORD_W'(p1Valid), WORD_W'(expV1));
    if (expV0) begin
      chk(p0RdWay0 === exp00, tag0, "p0 way0 data", p0RdWay0, exp00);
      chk(p0RdWay1 === exp01, tag0, "p0 way1 data", p0RdWay1, exp01);
    end
    if (expV1) begin
      chk(p1RdWay0 === exp10, tag1, "p1 way0 data", p1RdWay0, exp10);
      chk(p1RdWay1 === exp11, tag1, "p1 way1 data", p1RdWay1, exp11);
    end
    p0Req = r0; p0Wr = w0; p0Way = y0; p0Addr = a0; p0WData = d0; p0Be = b0;
    p1Req = r1; p1Wr = w1; p1Way = y1; p1Addr = a1; p1WData = d1; p1Be = b1;
    #1;
    conf = r0 && r1 && (a0[BYTE_W +: BANK_W] == a1[BYTE_W +: BANK_W]);
    chk(p1Retry == conf, conf ? "R4" : (r0 && r1 ? "R2" : "R8"), "p1Retry",
        WORD_W'(p1Retry), WORD_W'(conf));
    expV0 = r0 && !w0;
    expV1 = r1 && !w1 && !conf;
    tag0 = t0; tag1 = t1;
    if (expV0) begin exp00 = shadow[0][slot(a0)]; exp01 = shadow[1][slot(a0)]; end
    if (expV1) begin exp10 = shadow[0][slot(a1)]; exp11 = shadow[1][slot(a1)]; end
    if (r0 && w0) shadow[y0][slot(a0)] = merge(shadow[y0][slot(a0)], d0, b0);
    if (r1 && w1 && !conf) shadow[y1][slot(a1)] = merge(shadow[y1][slot(a1)], d1, b1);
  endtask

  task automatic idle();
    step(0,0,0,'0,'0,'0, 0,0,0,'0,'0,'0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!p0Valid && !p1Valid && !p1Retry, "R9", "flags", WORD_W'({p0Valid,p1Valid,p1Retry}), '0);
    chk(p0RdWay0 == 0 && p0RdWay1 == 0 && p1RdWay0 == 0 && p1RdWay1 == 0, "R9", "read data",
        p0RdWay0 | p0RdWay1 | p1RdWay0 | p1RdWay1, '0);
    rstN = 1'b1;

    // initialise the used sets; both ports in distinct banks (R2, R6)
    for (int si = 0; si < 4; si++)
      for (int w = 0; w < WAYS; w++)
        for (int b = 0; b < BANKS; b += 2)
          step(1,1,w[0],mkAddr(setPick[si],b,0),{$urandom,$urandom},'1,
               1,1,w[0],mkAddr(setPick[si],b+1,0),{$urandom,$urandom},'1, "R2","R2");

    // read back whole lines on both ports; consecutive words in adjacent banks (R1, R3)
    for (int si = 0; si < 4; si++)
      for (int b = 0; b < BANKS; b += 2)
        step(1,0,0,mkAddr(setPick[si],b,0),'0,'0, 1,0,0,mkAddr(setPick[si],b+1,0),'0,'0, "R1","R3");

    // R4: write/write collision, port 1 write dropped, then read its target
    step(1,1,0,mkAddr(0,3,0),64'h1111_2222_3333_4444,'1, 1,1,0,mkAddr(1,3,0),64'hdead_beef_dead_beef,'1, "R5","R4");
    step(0,0,0,'0,'0,'0, 1,0,0,mkAddr(1,3,0),'0,'0, "R5","R4");
    step(1,0,0,mkAddr(0,3,0),'0,'0, 0,0,0,'0,'0,'0, "R5","R4");
    // R4: read/read collision, no port 1 valid
    step(1,0,0,mkAddr(2,6,0),'0,'0, 1,0,0,mkAddr(0,6,0),'0,'0, "R5","R4");
    // R8: idle port 0 with same bank address
    step(0,0,0,mkAddr(0,5,0),'0,'0, 1,0,0,mkAddr(0,5,0),'0,'0, "R8","R8");
    // R6: partial byte enables into way 1 only
    step(1,1,1,mkAddr(511,7,0),64'haaaa_bbbb_cccc_dddd,8'b1010_0101, 0,0,0,'0,'0,'0, "R7","R6");
    step(0,0,0,'0,'0,'0, 1,0,0,mkAddr(511,7,0),'0,'0, "R7","R6");
    // R1: byte offset bits ignored
    step(1,0,0,mkAddr(511,7,5),'0,'0, 1,0,0,mkAddr(2,4,7),'0,'0, "R1","R1");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int s0 = setPick[$urandom % 4], s1 = setPick[$urandom % 4];
      step($urandom%4 != 0, $urandom%2, $urandom%2, mkAddr(s0,$urandom%8,$urandom%8), {$urandom,$urandom}, BE_W'($urandom),
           $urandom%4 != 0, $urandom%2, $urandom%2, mkAddr(s1,$urandom%8,$urandom%8), {$urandom,$urandom}, BE_W'($urandom),
           "R6","R4");
    end
    idle();
    idle();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule